// File: doc/BRIEF.md
# Initialisation alarm status register

This block is a 16-bit status word that a supervisor reaches through a plain access port. The port carries a valid strobe, a write enable, a memory identifier, an address and write data. The word answers only at memory identifier 2, address 0x0010. One of its bits is a sticky init-request flag. A hardware reset sets this flag, and the flag alone drives the upstream alarm indication. The alarm therefore stays raised after power-up until the supervisor has finished re-initialising the system and clears the flag by writing.

The remaining bits are status flags that belong to the block's surroundings. They are copied in from a status input on every 8 kHz frame strobe. A supervisor write may overwrite them, for example a blanket write of 0x0000, but the next frame strobe restores them, so such a write does no lasting harm. Reads return the contents of the word one clock after the request.

Top module: `init_alarm_reg`

## Requirements
- R1: While reset is high and just after it is released, the word holds 0x0004: the init-request flag (bit 2) is set and all other bits are 0. The alarm output `alarm_up` is 1.
- R2: `alarm_up` always equals bit 2 of the word. Every read therefore returns in bit 2 the value `alarm_up` had in the request cycle.
- R3: A write that hits the word with bit 2 of the data equal to 0 clears the init-request flag. From the next cycle on, `alarm_up` is 0. Writing the value just read ANDed with 0xFFFB clears only this flag, and writing 0x0000 clears every bit.
- R4: Writing 1 to bit 2 never sets the init-request flag. Only reset sets it.
- R5: On a cycle with `frame_strobe` high, every bit except bit 2 takes the matching bit of `status_in`.
- R6: A write that hits the word loads every bit except bit 2 from the write data. The value holds until the next frame strobe replaces it.
- R7: When a hitting write and a frame strobe fall in the same cycle, the non-init bits take `status_in`. The init-request flag follows the write.
- R8: A read request that hits the word (valid high, write low) gives `rd_valid` high in the next cycle. `rd_data` then holds the word as it was in the request cycle, before any update made in that same cycle.
- R9: An access whose memory identifier or address differs from 2 / 0x0010 leaves the word unchanged. Such a read does not raise `rd_valid`.
- R10: Bit 2 of `status_in` is ignored. A frame strobe never changes the init-request flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_memid | input | 4 | Memory identifier of the access |
| acc_addr | input | 16 | Address of the access |
| acc_wdata | input | 16 | Write data |
| frame_strobe | input | 1 | 8 kHz refresh pulse, one clock wide |
| status_in | input | 16 | Status bits copied in on each frame strobe (bit 2 unused) |
| rd_valid | output | 1 | Read data valid, one cycle after a hitting read |
| rd_data | output | 16 | Read data |
| alarm_up | output | 1 | Upstream alarm indication, equals the init-request flag |

## Verification
Two collisions matter here. The first is a supervisor write landing in the same clock as a frame strobe. The bench provokes it by writing 0x0000 while a strobe carries a nonzero status pattern. It passes only if the next read shows the strobed status bits and a cleared init-request flag. The second is a read that coincides with a strobe. It must return the contents from before the strobe, and a following read must show the refreshed value.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int unsigned REG_W      = 16;
    localparam int unsigned INIT_BIT   = 2;
    localparam int unsigned MEMID_W    = 4;
    localparam int unsigned ADDR_W     = 16;
    localparam int unsigned ALM_MEMID  = 2;
    localparam int unsigned ALM_ADDR   = 16'h0010;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [REG_W-1:0] data;
    } req_t;

    // Mask that keeps every bit except the sticky init-request flag.
    function automatic logic [REG_W-1:0] refresh_mask();
        logic [REG_W-1:0] m;
        m = '1;
        m[INIT_BIT] = 1'b0;
        return m;
    endfunction

endpackage

// File: rtl/alm_decode.sv
module alm_decode
    import alm_pkg::*;
#(
    parameter int unsigned MEMID_W  = alm_pkg::MEMID_W,
    parameter int unsigned ADDR_W   = alm_pkg::ADDR_W,
    parameter int unsigned MEM_ID   = alm_pkg::ALM_MEMID,
    parameter int unsigned REG_ADDR = alm_pkg::ALM_ADDR
) (
    input  logic               valid,
    input  logic               write,
    input  logic [MEMID_W-1:0] memid,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wdata,
    output req_t               req
);
    localparam logic [MEMID_W-1:0] ID_MATCH   = MEMID_W'(MEM_ID);
    localparam logic [ADDR_W-1:0]  ADDR_MATCH = ADDR_W'(REG_ADDR);

    logic hit;

    always_comb begin
        hit      = valid && (memid == ID_MATCH) && (addr == ADDR_MATCH);
        req.data = wdata;
        if (!hit)
            req.op = OP_NONE;
        else if (write)
            req.op = OP_WRITE;
        else
            req.op = OP_READ;
    end
endmodule

// File: rtl/alm_store.sv
module alm_store
    import alm_pkg::*;
#(
    parameter int unsigned FLAG_POS = alm_pkg::INIT_BIT
) (
    input  logic             clk,
    input  logic             rst,
    input  req_t             req,
    input  logic             frame_strobe,
    input  logic [REG_W-1:0] status_in,
    output logic [REG_W-1:0] reg_q
);
    localparam logic [REG_W-1:0] KEEP = refresh_mask();

    logic [REG_W-1:0] other_q;
    logic             init_q;

    // Non-init bits: the strobe has priority over a supervisor write.
    always_ff @(posedge clk) begin
        if (rst)
            other_q <= '0;
        else if (frame_strobe)
            other_q <= status_in & KEEP;
        else if (req.op == OP_WRITE)
            other_q <= req.data & KEEP;
    end

    // Sticky flag: only reset sets it, a write may only clear it.
    always_ff @(posedge clk) begin
        if (rst)
            init_q <= 1'b1;
        else if (req.op == OP_WRITE)
            init_q <= init_q & req.data[FLAG_POS];
    end

    always_comb begin
        reg_q           = other_q;
        reg_q[FLAG_POS] = init_q;
    end
endmodule

// File: rtl/alm_readout.sv
module alm_readout
    import alm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_hit,
    input  logic [REG_W-1:0] reg_q,
    output logic             rd_valid,
    output logic [REG_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_hit;
            if (rd_hit)
                rd_data <= reg_q;
        end
    end
endmodule

// File: rtl/init_alarm_reg.sv
module init_alarm_reg
    import alm_pkg::*;
#(
    parameter int unsigned MEMID_W  = alm_pkg::MEMID_W,
    parameter int unsigned ADDR_W   = alm_pkg::ADDR_W,
    parameter int unsigned MEM_ID   = alm_pkg::ALM_MEMID,
    parameter int unsigned REG_ADDR = alm_pkg::ALM_ADDR
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [MEMID_W-1:0] acc_memid,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [REG_W-1:0]   acc_wdata,
    input  logic               frame_strobe,
    input  logic [REG_W-1:0]   status_in,
    output logic               rd_valid,
    output logic [REG_W-1:0]   rd_data,
    output logic               alarm_up
);
    req_t             req;
    logic [REG_W-1:0] reg_q;
    logic             rd_hit;

    alm_decode #(
        .MEMID_W (MEMID_W),
        .ADDR_W  (ADDR_W),
        .MEM_ID  (MEM_ID),
        .REG_ADDR(REG_ADDR)
    ) u_decode (
        .valid(acc_valid),
        .write(acc_write),
        .memid(acc_memid),
        .addr (acc_addr),
        .wdata(acc_wdata),
        .req  (req)
    );

    alm_store #(.FLAG_POS(INIT_BIT)) u_store (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .frame_strobe(frame_strobe),
        .status_in   (status_in),
        .reg_q       (reg_q)
    );

    assign rd_hit = (req.op == OP_READ);

    alm_readout u_readout (
        .clk     (clk),
        .rst     (rst),
        .rd_hit  (rd_hit),
        .reg_q   (reg_q),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );

    assign alarm_up = reg_q[INIT_BIT];
endmodule

// File: rtl/init_alarm_reg_chk.sv
module init_alarm_reg_chk
    import alm_pkg::*;
#(
    parameter int unsigned MEMID_W  = alm_pkg::MEMID_W,
    parameter int unsigned ADDR_W   = alm_pkg::ADDR_W,
    parameter int unsigned MEM_ID   = alm_pkg::ALM_MEMID,
    parameter int unsigned REG_ADDR = alm_pkg::ALM_ADDR
) (
    input logic               clk,
    input logic               rst,
    input logic               acc_valid,
    input logic               acc_write,
    input logic [MEMID_W-1:0] acc_memid,
    input logic [ADDR_W-1:0]  acc_addr,
    input logic [REG_W-1:0]   acc_wdata,
    input logic               frame_strobe,
    input logic [REG_W-1:0]   status_in,
    input logic               rd_valid,
    input logic [REG_W-1:0]   rd_data,
    input logic               alarm_up,
    input logic [REG_W-1:0]   reg_q
);
    localparam logic [REG_W-1:0] KEEP = refresh_mask();

    logic hit;
    assign hit = acc_valid && (acc_memid == MEMID_W'(MEM_ID))
                           && (acc_addr == ADDR_W'(REG_ADDR));

    AST_FLAG_NEVER_RISES: assert property (@(posedge clk) disable iff (rst)
        !$rose(alarm_up));                                                 // R4
    AST_CLEAR_DROPS_ALARM: assert property (@(posedge clk) disable iff (rst)
        (hit && acc_write && !acc_wdata[INIT_BIT]) |=> !alarm_up);         // R3
    AST_STROBE_LOADS: assert property (@(posedge clk) disable iff (rst)
        frame_strobe |=> ((reg_q & KEEP) == ($past(status_in) & KEEP)));   // R5
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (hit && !acc_write) |=> rd_valid);                                 // R8
    AST_READ_FLAG_BIT: assert property (@(posedge clk) disable iff (rst)
        (hit && !acc_write) |=> (rd_data[INIT_BIT] == $past(alarm_up)));   // R2
    AST_MISS_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (!frame_strobe && !(hit && acc_write)) |=> $stable(reg_q));        // R9
endmodule

bind init_alarm_reg init_alarm_reg_chk #(
    .MEMID_W (MEMID_W),
    .ADDR_W  (ADDR_W),
    .MEM_ID  (MEM_ID),
    .REG_ADDR(REG_ADDR)
) u_chk (.*);

// File: tb/init_alarm_reg_bench.sv
module init_alarm_reg_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_memid = '0;
    logic [15:0] acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic        frame_strobe = 1'b0;
    logic [15:0] status_in = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        alarm_up;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    // independent reference state
    logic        m_init;
    logic [15:0] m_other;

    always #(CLK_PERIOD/2) clk = ~clk;

    init_alarm_reg u_init_alarm_reg (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_memid(acc_memid), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .frame_strobe(frame_strobe), .status_in(status_in),
        .rd_valid(rd_valid), .rd_data(rd_data), .alarm_up(alarm_up)
    );

    function automatic logic [15:0] model_word();
        logic [15:0] w;
        w = m_other;
        w[2] = m_init;
        return w;
    endfunction

    // monitor: pops expected read results
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R9: unexpected rd_valid, actual data %h expected no read", rd_data);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_bad++;
                    $display("FAIL %s: read actual %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    // driver: one cycle of access, optionally with a frame strobe
    task automatic cycle(input bit v, input bit w, input logic [3:0] mid,
                         input logic [15:0] a, input logic [15:0] d,
                         input bit stb, input logic [15:0] st, input string tag);
        bit hit;
        hit = v && mid == 4'd2 && a == 16'h0010;
        acc_valid = v; acc_write = w; acc_memid = mid; acc_addr = a;
        acc_wdata = d; frame_strobe = stb; status_in = st;
        if (hit && !w) begin
            exp_q.push_back(model_word());
            tag_q.push_back(tag);
        end
        if (hit && w) m_init = m_init & d[2];
        if (stb) m_other = st & 16'hFFFB;
        else if (hit && w) m_other = d & 16'hFFFB;
        @(negedge clk);
        acc_valid = 0; acc_write = 0; frame_strobe = 0;
    endtask

    task automatic rd(input string tag);
        cycle(1, 0, 4'd2, 16'h0010, 16'h0, 0, 16'h0, tag);
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        cycle(1, 1, 4'd2, 16'h0010, d, 0, 16'h0, "");
    endtask

    task automatic strobe(input logic [15:0] st);
        cycle(0, 0, 4'd0, 16'h0, 16'h0, 1, st, "");
    endtask

    task automatic chk_alarm(input logic e, input string tag);
        n_cmp++;
        if (alarm_up !== e) begin
            n_bad++;
            $display("FAIL %s: alarm_up actual %b expected %b", tag, alarm_up, e);
        end
    endtask

    task automatic do_reset();
        rst = 1;
        m_init = 1; m_other = '0;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk_alarm(1, "R1");
        rd("R1");                                   // 0x0004
        strobe(16'hFFFF);                           // R5, bit 2 ignored (R10)
        rd("R5");                                   // 0xFFFF
        cycle(1, 1, 4'd2, 16'h0011, 16'h0000, 0, 16'h0, "");   // R9 wrong address
        cycle(1, 1, 4'd3, 16'h0010, 16'h0000, 0, 16'h0, "");   // R9 wrong memid
        cycle(1, 0, 4'd1, 16'h0010, 16'h0000, 0, 16'h0, "");   // R9 wrong-id read
        @(negedge clk);
        chk_alarm(1, "R9");
        rd("R9");                                   // 0xFFFF unchanged
        wr(16'hFFFF & 16'hFFFB);                    // R3 clear only the flag
        chk_alarm(0, "R3");
        rd("R3");                                   // 0xFFFB
        wr(16'hFFFF);                               // R4 writing 1 does nothing
        chk_alarm(0, "R4");
        rd("R4");                                   // 0xFFFB
        strobe(16'h1236);                           // R10 bit 2 of status ignored
        chk_alarm(0, "R10");
        rd("R10");                                  // 0x1232
        wr(16'h00A5);                               // R6
        rd("R6");                                   // 0x00A1
        strobe(16'h5555);
        rd("R6");                                   // 0x5551 restored by refresh
        rd("R2");                                   // bit 2 zero with alarm low
        // second reset: collision of write and strobe
        do_reset();
        chk_alarm(1, "R1");
        cycle(1, 1, 4'd2, 16'h0010, 16'h0000, 1, 16'h8001, "");   // R7
        chk_alarm(0, "R7");
        rd("R7");                                   // 0x8001
        // read coinciding with a strobe returns pre-strobe value
        cycle(1, 0, 4'd2, 16'h0010, 16'h0, 1, 16'h0F0F, "R8");     // 0x8001
        @(negedge clk);
        rd("R8");                                   // 0x0F0B
        // third reset: blanket clear with 0x0000
        do_reset();
        wr(16'h0000);
        chk_alarm(0, "R3");
        rd("R3");                                   // 0x0000
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R8: %0d reads without rd_valid, actual missing expected 0", exp_q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule